// File: doc/BRIEF.md
# ADC Channel Sequencer and Power Controller

This block is the digital control core of a four-channel serial converter. A frame is the span during which the active-low chip select is held low. Inside each frame the block counts the rising edges of the serial clock, which reach it as one-cycle pulses in the system clock domain. The control, sequence and range registers are not shifted in here. They arrive as parallel write strobes. The control write carries a two-bit power mode, a two-bit sequencing mode and a channel address. The sequence register is a per-channel enable mask. The range bank holds one range code for each channel.

At the start of every frame the block picks the channel to convert and latches that channel's range code. It can take the channel from three sources: the channel address alone, the enabled channels of the mask in rising order, or a sweep from channel 0 up to the address. It also drives two power-enable outputs. One is for the analog core and one is for the reference. In the automatic modes it drops power on the 15th clock edge of a frame and brings it back when the next frame opens. That next frame is flagged so that its result can be discarded.

Top module: `adcseq_ctrl`

## Requirements
- R1: Power-mode code 00 (normal) keeps `core_pwr_on` and `ref_pwr_on` high in every frame, whatever the edge count, and frames in this mode do not raise `conv_wake`.
- R2: Power-mode code 11 (full shutdown) drops both power enables in the cycle after the write, and keeps them low across frames. Frames that open in this mode do not raise `conv_wake`. The mode settings and range codes survive it, and the first frame after a write to another mode is powered and flagged as a wake frame.
- R3: Power-mode code 10 (auto shutdown) drops both power enables at the 15th serial clock rising edge of a frame, and not before.
- R4: Power-mode code 01 (auto standby) drops `core_pwr_on` at the 15th rising edge and keeps `ref_pwr_on` high. `core_pwr_on` is never high while `ref_pwr_on` is low.
- R5: A low-power state entered automatically ends when chip select next falls. Both enables are high again in the cycle after the fall, and `conv_wake` is 1 for that frame. The next frame has no power-down in between, so it reports `conv_wake` 0.
- R6: The edge count restarts each time chip select falls, and it ignores clock pulses while chip select is high. It saturates at 16, so the 15th-edge event fires at most once per frame, even when an automatic mode is written after edge 16.
- R7: Sequencing code 00 or 11 converts the channel given by the address field.
- R8: Sequencing code 01 converts the channels whose mask bit (bit n = channel n) is set. It starts at the lowest set bit, goes up in rising order and wraps around. After a mask change it continues from the next set bit above the last channel.
- R9: Sequencing code 10 converts channels 0, 1, … up to the address field, then repeats from 0.
- R10: `conv_rng` is the range code most recently written for the selected channel, captured when the frame opens.
- R11: A control write that changes the sequencing code or the address restarts the order at the first channel of the new sequence. A write with the same fields does not restart it. A write in the same cycle as the chip-select fall already governs that frame.
- R12: In sequencing code 01 with an all-zero mask, the address field selects the channel.
- R13: `conv_go` pulses for one cycle, one cycle after each chip-select fall. `conv_ch`, `conv_rng` and `conv_wake` are valid from that cycle on. After reset they are 0 and both power enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk_rise | input | 1 | One-cycle pulse per serial clock rising edge |
| ctl_we | input | 1 | Control register write strobe |
| ctl_pm | input | 2 | Power-mode code |
| ctl_seq | input | 2 | Sequencing-mode code |
| ctl_addr | input | 2 | Channel address |
| seq_we | input | 1 | Sequence mask write strobe |
| seq_mask | input | 4 | Channel enable mask, bit n = channel n |
| rng_we | input | 1 | Range write strobe |
| rng_ch | input | 2 | Channel whose range is written |
| rng_code | input | 2 | Range code |
| conv_go | output | 1 | Frame-start pulse, selection valid |
| conv_ch | output | 2 | Channel to convert |
| conv_rng | output | 2 | Range code for that channel |
| conv_wake | output | 1 | Frame follows a power-down; result invalid |
| core_pwr_on | output | 1 | Analog core power enable |
| ref_pwr_on | output | 1 | Reference power enable |

## Verification
A control write and a chip-select fall can land on the same clock edge. In that cycle, channel selection, restart and wake decisions all have to use the newly written fields rather than the stored ones. The bench provokes this by raising the write strobe in the cycle where chip select drops, switching from a running sweep to a fixed address. The scoreboard expects the new address on that very frame's `conv_go`, with no one-frame lag.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL    = 2'b00,
    PM_AUTO_STBY = 2'b01,
    PM_AUTO_SHDN = 2'b10,
    PM_FULL_OFF  = 2'b11
  } pm_e;

  typedef enum logic [1:0] {
    SQ_FIXED_A = 2'b00,
    SQ_MASK    = 2'b01,
    SQ_SWEEP   = 2'b10,
    SQ_FIXED_B = 2'b11
  } sq_e;

  typedef enum logic [1:0] {
    PW_ON   = 2'b00,
    PW_STBY = 2'b01,
    PW_OFF  = 2'b10
  } pw_e;

  function automatic logic pm_is_auto(input pm_e m);
    return (m == PM_AUTO_STBY) || (m == PM_AUTO_SHDN);
  endfunction

endpackage

// File: rtl/adcseq_edge_cnt.sv
module adcseq_edge_cnt #(
  parameter int EDGE_MAX  = 16,
  parameter int EDGE_FIRE = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic cs_active,
  input  logic sclk_rise,
  output logic fire
);
  localparam int CW = $clog2(EDGE_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (frame_start)
      cnt_q <= '0;
    else if (cs_active && sclk_rise && cnt_q != CW'(EDGE_MAX))
      cnt_q <= cnt_q + CW'(1);
  end

  assign fire = cs_active && sclk_rise && !frame_start && (cnt_q == CW'(EDGE_FIRE - 1));

  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(EDGE_MAX)); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> cnt_q == '0); // R6
  AST_FIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == CW'(EDGE_FIRE)); // R6

endmodule

// File: rtl/adcseq_pwr_ctl.sv
module adcseq_pwr_ctl
  import adcseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic fire,
  input  pm_e  pm_eff,
  output logic core_on,
  output logic ref_on,
  output logic wake
);
  pw_e  state_q, state_d;
  logic wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = wake_q;
    if (frame_start)
      wake_d = (state_q != PW_ON) && (pm_eff != PM_FULL_OFF);
    if (pm_eff == PM_FULL_OFF)
      state_d = PW_OFF;
    else if (frame_start)
      state_d = PW_ON;
    else if (fire && pm_is_auto(pm_eff))
      state_d = (pm_eff == PM_AUTO_STBY) ? PW_STBY : PW_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_ON;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign core_on = (state_q == PW_ON);
  assign ref_on  = (state_q != PW_OFF);
  assign wake    = wake_q;

  AST_CORE_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    core_on |-> ref_on); // R4
  AST_WAKE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !core_on && pm_eff != PM_FULL_OFF |=> wake && core_on); // R5
  AST_FULL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    pm_eff == PM_FULL_OFF |=> !ref_on && !core_on); // R2
  AST_NORMAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    core_on && pm_eff == PM_NORMAL |=> core_on); // R1

endmodule

// File: rtl/adcseq_chan_sel.sv
module adcseq_chan_sel
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RNG_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_start,
  input  sq_e                         sq_eff,
  input  logic [$clog2(NUM_CH)-1:0]   addr_eff,
  input  logic [NUM_CH-1:0]           mask_eff,
  input  logic                        restart_eff,
  input  logic                        rng_we,
  input  logic [$clog2(NUM_CH)-1:0]   rng_ch,
  input  logic [RNG_W-1:0]            rng_code,
  output logic [$clog2(NUM_CH)-1:0]   ch_q,
  output logic [RNG_W-1:0]            rng_q
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0]            bank_hit;
  logic [NUM_CH-1:0][RNG_W-1:0] bank_q;
  logic [CH_W-1:0]              sel;

  function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] m);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (m[i]) r = CH_W'(i);
    return r;
  endfunction

  function automatic logic [CH_W-1:0] next_set(input logic [NUM_CH-1:0] m,
                                               input logic [CH_W-1:0]   prev);
    logic [CH_W-1:0] r;
    r = prev;
    for (int i = NUM_CH - 1; i >= 1; i--) begin
      int k;
      k = (int'(prev) + i) % NUM_CH;
      if (m[k]) r = CH_W'(k);
    end
    return r;
  endfunction

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_hit
      assign bank_hit[g] = rng_we && (rng_ch == CH_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bank_q <= '0;
    else
      for (int i = 0; i < NUM_CH; i++)
        if (bank_hit[i]) bank_q[i] <= rng_code;
  end

  always_comb begin
    case (sq_eff)
      SQ_MASK: begin
        if (mask_eff == '0)    sel = addr_eff;
        else if (restart_eff)  sel = lowest_set(mask_eff);
        else                   sel = next_set(mask_eff, ch_q);
      end
      SQ_SWEEP: sel = (restart_eff || ch_q >= addr_eff) ? '0 : ch_q + CH_W'(1);
      default:  sel = addr_eff;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '0;
      rng_q <= '0;
    end else if (frame_start) begin
      ch_q  <= sel;
      rng_q <= bank_q[sel];
    end
  end

  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && sq_eff == SQ_SWEEP |=> ch_q <= $past(addr_eff)); // R9
  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && (sq_eff == SQ_FIXED_A || sq_eff == SQ_FIXED_B)
      |=> ch_q == $past(addr_eff)); // R7
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && sq_eff == SQ_MASK && mask_eff == '0
      |=> ch_q == $past(addr_eff)); // R12

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int RNG_W     = 2,
  parameter int EDGE_MAX  = 16,
  parameter int EDGE_FIRE = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sclk_rise,
  input  logic                      ctl_we,
  input  logic [1:0]                ctl_pm,
  input  logic [1:0]                ctl_seq,
  input  logic [$clog2(NUM_CH)-1:0] ctl_addr,
  input  logic                      seq_we,
  input  logic [NUM_CH-1:0]         seq_mask,
  input  logic                      rng_we,
  input  logic [$clog2(NUM_CH)-1:0] rng_ch,
  input  logic [RNG_W-1:0]          rng_code,
  output logic                      conv_go,
  output logic [$clog2(NUM_CH)-1:0] conv_ch,
  output logic [RNG_W-1:0]          conv_rng,
  output logic                      conv_wake,
  output logic                      core_pwr_on,
  output logic                      ref_pwr_on
);
  localparam int CH_W = $clog2(NUM_CH);

  pm_e               pm_q, pm_eff;
  sq_e               sq_q, sq_eff;
  logic [CH_W-1:0]   addr_q, addr_eff;
  logic [NUM_CH-1:0] mask_q, mask_eff;
  logic              restart_q, restart_eff;
  logic              cs_q, go_q;
  logic              frame_start, fire;

  assign frame_start = cs_q && !cs_n;
  assign pm_eff      = ctl_we ? pm_e'(ctl_pm)  : pm_q;
  assign sq_eff      = ctl_we ? sq_e'(ctl_seq) : sq_q;
  assign addr_eff    = ctl_we ? ctl_addr       : addr_q;
  assign mask_eff    = seq_we ? seq_mask       : mask_q;
  assign restart_eff = restart_q ||
                       (ctl_we && (ctl_seq != sq_q || ctl_addr != addr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q      <= PM_NORMAL;
      sq_q      <= SQ_FIXED_A;
      addr_q    <= '0;
      mask_q    <= '0;
      restart_q <= 1'b1;
      cs_q      <= 1'b1;
      go_q      <= 1'b0;
    end else begin
      pm_q      <= pm_eff;
      sq_q      <= sq_eff;
      addr_q    <= addr_eff;
      mask_q    <= mask_eff;
      restart_q <= frame_start ? 1'b0 : restart_eff;
      cs_q      <= cs_n;
      go_q      <= frame_start;
    end
  end

  adcseq_edge_cnt #(.EDGE_MAX(EDGE_MAX), .EDGE_FIRE(EDGE_FIRE)) i_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cs_active   (!cs_n),
    .sclk_rise   (sclk_rise),
    .fire        (fire)
  );

  adcseq_pwr_ctl i_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .fire        (fire),
    .pm_eff      (pm_eff),
    .core_on     (core_pwr_on),
    .ref_on      (ref_pwr_on),
    .wake        (conv_wake)
  );

  adcseq_chan_sel #(.NUM_CH(NUM_CH), .RNG_W(RNG_W)) i_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .sq_eff      (sq_eff),
    .addr_eff    (addr_eff),
    .mask_eff    (mask_eff),
    .restart_eff (restart_eff),
    .rng_we      (rng_we),
    .rng_ch      (rng_ch),
    .rng_code    (rng_code),
    .ch_q        (conv_ch),
    .rng_q       (conv_rng)
  );

  assign conv_go = go_q;

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go); // R13
  AST_GO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> conv_go); // R13
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !restart_q); // R11

endmodule

// File: tb/test_adcseq_ctrl.sv
module test_adcseq_ctrl;
  localparam int NCH = 4;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sclk_rise, ctl_we, seq_we, rng_we;
  logic [1:0] ctl_pm, ctl_seq, ctl_addr, rng_ch, rng_code;
  logic [3:0] seq_mask;
  logic       conv_go, conv_wake, core_pwr_on, ref_pwr_on;
  logic [1:0] conv_ch, conv_rng;

  always #2 clk = ~clk;

  adcseq_ctrl i_adcseq_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
    .ctl_we(ctl_we), .ctl_pm(ctl_pm), .ctl_seq(ctl_seq), .ctl_addr(ctl_addr),
    .seq_we(seq_we), .seq_mask(seq_mask), .rng_we(rng_we), .rng_ch(rng_ch),
    .rng_code(rng_code), .conv_go(conv_go), .conv_ch(conv_ch),
    .conv_rng(conv_rng), .conv_wake(conv_wake), .core_pwr_on(core_pwr_on),
    .ref_pwr_on(ref_pwr_on)
  );

  typedef struct { int ch; int rng; int wake; string tag; } exp_t;
  exp_t sbq[$];

  int n_chk = 0, n_bad = 0;
  int m_pm = 0, m_sq = 0, m_addr = 0, m_mask = 0, m_prev = 0;
  int m_restart = 1, m_lp = 0, m_edges = 0;
  int m_rng[NCH] = '{0, 0, 0, 0};
  string phase = "R13";
  bit done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_pick();
    if (m_sq == 1) begin
      if (m_mask == 0) return m_addr;
      if (m_restart != 0) begin
        for (int c = 0; c < NCH; c++) if (m_mask[c]) return c;
      end
      for (int s = 1; s <= NCH; s++) begin
        int c;
        c = (m_prev + s) % NCH;
        if (m_mask[c]) return c;
      end
      return m_prev;
    end
    if (m_sq == 2) return (m_restart != 0 || m_prev >= m_addr) ? 0 : m_prev + 1;
    return m_addr;
  endfunction

  task automatic set_ctl(int pm, int sq, int addr);
    if (sq != m_sq || addr != m_addr) m_restart = 1;
    m_pm = pm; m_sq = sq; m_addr = addr;
    if (pm == 3) m_lp = 1;
    ctl_we = 1'b1; ctl_pm = 2'(pm); ctl_seq = 2'(sq); ctl_addr = 2'(addr);
  endtask

  task automatic ctl(int pm, int sq, int addr);
    @(negedge clk); set_ctl(pm, sq, addr);
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic seqw(int mask);
    @(negedge clk); seq_we = 1'b1; seq_mask = 4'(mask); m_mask = mask;
    @(negedge clk); seq_we = 1'b0;
  endtask

  task automatic rngw(int ch, int code);
    @(negedge clk); rng_we = 1'b1; rng_ch = 2'(ch); rng_code = 2'(code);
    m_rng[ch] = code;
    @(negedge clk); rng_we = 1'b0;
  endtask

  task automatic open_frame(bit with_ctl, int pm, int sq, int addr);
    exp_t e;
    @(negedge clk);
    if (with_ctl) set_ctl(pm, sq, addr);
    e.ch = model_pick();
    e.rng = m_rng[e.ch];
    if (m_pm == 3) e.wake = 0;
    else begin e.wake = m_lp; m_lp = 0; end
    e.tag = phase;
    m_prev = e.ch; m_restart = 0; m_edges = 0;
    sbq.push_back(e);
    cs_n = 1'b0;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic pulses(int n);
    repeat (n) begin
      sclk_rise = 1'b1;
      @(negedge clk);
      sclk_rise = 1'b0;
      m_edges++;
      if (m_edges == 15 && (m_pm == 1 || m_pm == 2)) m_lp = 1;
    end
  endtask

  task automatic close_frame();
    cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic frame(int n);
    open_frame(0, 0, 0, 0); pulses(n); close_frame();
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && conv_go === 1'b1) begin
      if (sbq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R13: conv_go with empty queue, actual 1 expected 0");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " channel"}, int'(conv_ch), e.ch);
        check({"R10 range (", e.tag, ")"}, int'(conv_rng), e.rng);
        check({"R5 wake flag (", e.tag, ")"}, int'(conv_wake), e.wake);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk_rise = 1'b0; ctl_we = 1'b0; seq_we = 1'b0;
    rng_we = 1'b0; ctl_pm = '0; ctl_seq = '0; ctl_addr = '0; seq_mask = '0;
    rng_ch = '0; rng_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 reset conv_go", int'(conv_go), 0);
    check("R13 reset conv_ch", int'(conv_ch), 0);
    check("R13 reset conv_wake", int'(conv_wake), 0);
    check("R13 reset core", int'(core_pwr_on), 1);
    check("R13 reset ref", int'(ref_pwr_on), 1);

    rngw(0, 1); rngw(1, 2); rngw(2, 3); rngw(3, 0);

    // R7 fixed address, R1 normal mode stays powered past edge 15
    phase = "R7";
    ctl(0, 0, 2);
    open_frame(0, 0, 0, 0); pulses(16);
    check("R1 core after 16 edges", int'(core_pwr_on), 1);
    check("R1 ref after 16 edges", int'(ref_pwr_on), 1);
    close_frame();
    frame(16);
    ctl(0, 3, 1); frame(16);
    rngw(1, 3); frame(16);  // R10 updated range

    // R8 programmed mask
    phase = "R8";
    seqw(4'b1010); ctl(0, 1, 1);
    repeat (5) frame(16);
    seqw(4'b0101);
    repeat (3) frame(16);

    // R9 sweep; R11 restart and no-restart
    phase = "R9";
    ctl(0, 2, 2);
    repeat (5) frame(16);
    phase = "R11";
    ctl(0, 2, 3); frame(16); frame(16);
    ctl(0, 2, 3); frame(16); frame(16); frame(16);

    // R12 empty mask falls back to address
    phase = "R12";
    seqw(0); ctl(0, 1, 3); frame(16); frame(16);

    // R4 auto standby, R5 wake
    phase = "R4";
    ctl(1, 0, 0);
    open_frame(0, 0, 0, 0); pulses(14);
    check("R4 core before edge 15", int'(core_pwr_on), 1);
    pulses(1);
    check("R4 core at edge 15", int'(core_pwr_on), 0);
    check("R4 ref kept at edge 15", int'(ref_pwr_on), 1);
    pulses(2); close_frame();
    phase = "R5";
    open_frame(0, 0, 0, 0);
    check("R5 core after wake", int'(core_pwr_on), 1);
    pulses(14); close_frame();
    frame(3);

    // R6 counter restart on cs fall and idle pulses ignored
    phase = "R6";
    open_frame(0, 0, 0, 0); pulses(10); close_frame();
    repeat (10) begin
      @(negedge clk); sclk_rise = 1'b1;
      @(negedge clk); sclk_rise = 1'b0;
    end
    open_frame(0, 0, 0, 0); pulses(5);
    check("R6 no fire after restart", int'(core_pwr_on), 1);
    close_frame();
    // R6 saturation: auto mode written after edge 16
    ctl(0, 0, 0);
    open_frame(0, 0, 0, 0); pulses(20);
    ctl(1, 0, 0);
    pulses(30);
    check("R6 saturated, no late fire", int'(core_pwr_on), 1);
    close_frame();
    frame(2);

    // R3 auto shutdown
    phase = "R3";
    ctl(2, 0, 0);
    open_frame(0, 0, 0, 0); pulses(14);
    check("R3 ref before edge 15", int'(ref_pwr_on), 1);
    pulses(1);
    check("R3 core at edge 15", int'(core_pwr_on), 0);
    check("R3 ref at edge 15", int'(ref_pwr_on), 0);
    close_frame();
    open_frame(0, 0, 0, 0);
    check("R3 R5 core after wake", int'(core_pwr_on), 1);
    check("R3 R5 ref after wake", int'(ref_pwr_on), 1);
    pulses(2); close_frame();

    // R2 full shutdown with retention
    phase = "R2";
    ctl(3, 0, 2);
    check("R2 core off", int'(core_pwr_on), 0);
    check("R2 ref off", int'(ref_pwr_on), 0);
    frame(16);
    check("R2 stays off across frame", int'(ref_pwr_on), 0);
    ctl(0, 0, 2);
    check("R2 off until next frame", int'(core_pwr_on), 0);
    open_frame(0, 0, 0, 0);
    check("R2 powered on next frame", int'(core_pwr_on), 1);
    pulses(16); close_frame();

    // R11 write coinciding with chip-select fall
    phase = "R11";
    ctl(0, 2, 3); frame(16); frame(16);
    open_frame(1, 0, 0, 2); pulses(16); close_frame();
    frame(16);

    repeat (4) @(negedge clk);
    check("R13 scoreboard drained", sbq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule